// File: doc/BRIEF.md
# Wake-up and Reset Pulse Divider

This block is a slow timer that runs from a low-frequency oscillator of a few kilohertz. It has one free-running binary divider chain. Two taps on that chain generate two active-low pulses for an external microcontroller. The short tap fires when the low `WAKE_BITS` stages of the chain wrap, and it pulls `out_n` low so that the controller wakes up. The full tap fires when the whole `CHAIN_BITS` chain wraps, and it pulls `rst_n_out` low so that the controller is reset. Each pulse is exactly two oscillator cycles wide.

In standby, `out_n` rests high and drops only for divider pulses. Outside standby, `out_n` carries the comparator result `cmp_in`, and a divider pulse still forces it low. The full tap is a special case of the short tap, so every reset pulse lines up with a wake pulse on `out_n`. The chain counts in every mode. `standby` only selects what `out_n` shows between pulses.

Top module: `wake_reset_timer`

## Requirements
- R1: After reset the divider chain advances by one on every clock, whatever the value of `standby` or `cmp_in`.
- R2: Count the clock edges since the synchronous reset was released as k. A wake pulse is active in every cycle where k ≥ 2^WAKE_BITS and (k mod 2^WAKE_BITS) is 0 or 1.
- R3: Each pulse holds its output at logic 0 for exactly two consecutive clock cycles, and the output then returns to its idle level.
- R4: While `standby` is 1 and no pulse is active, `out_n` is 1.
- R5: `rst_n_out` is 0 exactly in the cycles where k ≥ 2^CHAIN_BITS and (k mod 2^CHAIN_BITS) is 0 or 1, in both modes. In all other cycles it is 1.
- R6: Whenever `rst_n_out` is 0, `out_n` is also 0.
- R7: While `standby` is 0 and no pulse is active, `out_n` equals `cmp_in` in the same cycle.
- R8: While `rst_n` is sampled 0, the chain clears and both pulses end. In that state `rst_n_out` is 1 and `out_n` shows the level that R4 or R7 gives it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Low-frequency oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| standby | input | 1 | 1 = standby, so `out_n` rests high between pulses |
| cmp_in | input | 1 | Comparator result, shown on `out_n` outside standby |
| out_n | output | 1 | Wake pulse output, low while a wake pulse is active |
| rst_n_out | output | 1 | Reset pulse output for the external controller, active low |

## Verification
The assertions check four things on every cycle: the chain steps by exactly one, each stretcher stays active for a second cycle and then releases, and a low `rst_n_out` is always matched by a low `out_n`. Only the bench scenarios can show the absolute pulse positions. These are the first wake pulse after 2^WAKE_BITS cycles, the reset pulse after 2^CHAIN_BITS cycles, and the timing that restarts after a reset in mid-run. The same holds for the selection between comparator and idle-high as `standby` toggles while pulses keep their schedule.

// File: rtl/wrt_pkg.sv
// Package: shared constants for the wake/reset divider.
// Assumes channel order is fixed: short tap first, full tap second.
package wrt_pkg;
    localparam int CH_WAKE  = 0;   // tap after the low stages
    localparam int CH_RESET = 1;   // tap at the full chain length
    localparam int NUM_CH   = 2;
    localparam int PULSE_CYCLES = 2;
endpackage

// File: rtl/wrt_divider.sv
// Module: free-running binary divider with two wrap taps.
// tick[CH_WAKE] is high in the cycle before the low WAKE_BITS wrap,
// tick[CH_RESET] in the cycle before the whole chain wraps.
// Assumes 2 <= WAKE_BITS < CHAIN_BITS.
module wrt_divider #(
    parameter int WAKE_BITS  = 14,
    parameter int CHAIN_BITS = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    output logic [wrt_pkg::NUM_CH-1:0] tick
);
    localparam logic [CHAIN_BITS-1:0] STEP = {{(CHAIN_BITS-1){1'b0}}, 1'b1};

    logic [CHAIN_BITS-1:0] stage_q;

    // Purpose: advance the chain every clock, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_q + STEP;
    end

    // Purpose: decode the two wrap points from the chain value.
    always_comb begin
        tick[wrt_pkg::CH_WAKE]  = &stage_q[WAKE_BITS-1:0];
        tick[wrt_pkg::CH_RESET] = &stage_q;
    end

    // R1: chain advances by one per clock in every mode
    p_chain_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (stage_q == $past(stage_q) + STEP));
endmodule

// File: rtl/wrt_stretch.sv
// Module: turns a one-cycle tick into an active flag lasting PULSE_CYCLES.
// Assumes ticks are at least PULSE_CYCLES+1 cycles apart.
module wrt_stretch (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic active
);
    logic [1:0] remain_q;

    // Purpose: load the width on a tick, count it down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)               remain_q <= '0;
        else if (tick)            remain_q <= 2'(wrt_pkg::PULSE_CYCLES);
        else if (remain_q != '0)  remain_q <= remain_q - 2'd1;
    end

    // Purpose: the pulse is active while width remains.
    assign active = (remain_q != '0);

    // R3: a pulse that starts stays for a second cycle
    p_width_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |=> active);
    // R3: after two active cycles the pulse ends
    p_width_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |=> !active);
endmodule

// File: rtl/wake_reset_timer.sv
// Module: top of the wake/reset timer. One divider chain, one stretcher
// per tap, output selection by mode. Assumes clk is the slow oscillator.
module wake_reset_timer #(
    parameter int WAKE_BITS  = 14,
    parameter int CHAIN_BITS = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic cmp_in,
    output logic out_n,
    output logic rst_n_out
);
    import wrt_pkg::*;

    logic [NUM_CH-1:0] tick;
    logic [NUM_CH-1:0] pulse_on;

    wrt_divider #(.WAKE_BITS(WAKE_BITS), .CHAIN_BITS(CHAIN_BITS)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    // One stretcher per divider tap.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        wrt_stretch u_str (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick[ch]),
            .active(pulse_on[ch])
        );
    end

    // Purpose: choose the out_n level from the pulses, the mode and the comparator.
    always_comb begin
        if (|pulse_on)    out_n = 1'b0;
        else if (standby) out_n = 1'b1;
        else              out_n = cmp_in;
        rst_n_out = ~pulse_on[CH_RESET];
    end

    // R6: a reset pulse is always visible on out_n too
    p_rst_on_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_n_out |-> !out_n);
endmodule

// File: tb/wake_reset_timer_test.sv
module wake_reset_timer_test;
    localparam int WB = 4;
    localparam int CB = 7;
    localparam int WP = 1 << WB;
    localparam int CP = 1 << CB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic standby = 1'b1;
    logic cmp_in = 1'b0;
    logic out_n, rst_n_out;

    int checks = 0;
    int fails = 0;
    int k = 0;
    bit done = 1'b0;

    typedef struct {
        logic  o;
        logic  r;
        string tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    wake_reset_timer #(.WAKE_BITS(WB), .CHAIN_BITS(CB)) uut (
        .clk(clk), .rst_n(rst_n), .standby(standby), .cmp_in(cmp_in),
        .out_n(out_n), .rst_n_out(rst_n_out)
    );

    // Edge count since reset release (bench model, not read from design)
    always @(posedge clk) begin
        if (!rst_n) k <= 0;
        else        k <= k + 1;
    end

    // Driver: compute expected outputs from the requirements and queue them
    task automatic drive(input logic sb, input logic cmp, input logic rn);
        exp_t e;
        bit wake, rpl;
        @(negedge clk);
        standby = sb;
        cmp_in  = cmp;
        #1;
        wake = (k >= WP) && ((k % WP) < 2);
        rpl  = (k >= CP) && ((k % CP) < 2);
        e.r = !rpl;
        if (wake || rpl) begin
            e.o = 1'b0;
            e.tag = rpl ? "R5/R6" : "R2/R3";
        end else if (sb) begin
            e.o = 1'b1;
            e.tag = "R4";
        end else begin
            e.o = cmp;
            e.tag = "R7";
        end
        if (k == 0) e.tag = "R8";
        q.push_back(e);
        rst_n = rn;
    endtask

    // Monitor: pop the expected item and compare with the ports
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (out_n !== e.o || rst_n_out !== e.r) begin
                    fails++;
                    $display("FAIL %s k=%0d out_n=%b rst_n_out=%b expected %b %b",
                             e.tag, k, out_n, rst_n_out, e.o, e.r);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R8: reset state in both modes
        drive(1'b1, 1'b0, 1'b0);
        drive(1'b0, 1'b1, 1'b0);
        drive(1'b0, 1'b0, 1'b1);
        // R1/R2/R5: run with mode toggling; the schedule must not shift
        for (int i = 0; i < 2 * CP + 40; i++) begin
            logic sb, cm;
            sb = ((i / 37) % 2) == 0;
            cm = (i % 3 == 0) ^ ((i / 5) % 2 == 1);
            drive(sb, cm, 1'b1);
        end
        // R8: mid-run reset, then the first wake pulse restarts after WP edges
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < CP + 10; i++) drive(1'b0, (i % 2 == 1), 1'b1);
        @(negedge clk);
        #3;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule